// File: doc/BRIEF.md
# Serial Measurement Output Port

This block hands a finished meter reading to a host controller over a three-wire style link. When the measurement core signals that a conversion has completed, the block formats the reading into a 16-bit frame and loads it into a shift register. It then raises an end-of-conversion flag. The host answers by toggling its own serial clock, and the frame comes out on a single data line, least significant bit first.

The frame carries the sign (voltage mode) or unit flag (frequency mode), the leading half-digit, three BCD digits and a two-bit decimal-point code. Three conditions replace the low six bits with fixed codes: the idle state after power-up, a positive overload and a negative overload. The host clock is asynchronous to the core clock. It is resynchronised, and its edges are detected in the core domain. The ready flag drops on the first host rising edge, or on its own after a programmable timeout (10 ms at the default core rate).

Top module: `meas_serial_port`

## Requirements
- R1: While and after reset, before any conversion-done strobe, `sdo_o` and `eoc_o` are both 0.
- R2: A cycle with `conv_done_i` high makes `eoc_o` high in the following cycle and loads a new frame, whose bit 0 appears on `sdo_o` in that same following cycle; `eoc_o` rises at no other time.
- R3: While `eoc_o` is high, a rising edge of `host_sclk_i` clears `eoc_o` within SYNC_STAGES+2 core cycles.
- R4: With no host activity, `eoc_o` stays high for exactly EOC_TIMEOUT core cycles after a strobe and then falls.
- R5: Frame bits leave bit 0 first; each falling edge of `host_sclk_i` advances `sdo_o` to the next bit (after SYNC_STAGES+1 core cycles), so the bit is stable at the host's rising edge; after all 16 bits `sdo_o` is 0.
- R6: Voltage mode (`freq_mode_i`=0): bit 0 is `positive_i` (1 = positive), bit 1 is `lead_one_i`, bits 5:2 hold `digit_a_i`, bits 9:6 hold `digit_b_i`, bits 13:10 hold `digit_c_i` (lowest bit of each digit in the lowest position), and bits 15:14 hold `dp_code_i` (0 none, 1/2/3 = first/second/third decimal point).
- R7: A digit input above 9 is sent as 9 (binary 1001).
- R8: Frequency mode (`freq_mode_i`=1): bit 0 is `unit_mhz_i` (1 = MHz, 0 = kHz) and `positive_i` is ignored; bits 15:1 are laid out as in R6.
- R9: Special frames: initial state gives low six bits 111111, positive overload 001111, negative overload 001110; bits 15:6 are 0 in these frames; priority is initial state, then positive overload, then negative overload.
- R10: Only a conversion-done strobe reloads the frame: input changes during a read do not alter the remaining bits, and a strobe during a read restarts output at bit 0 of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done_i | input | 1 | One-cycle strobe: a new reading is ready |
| freq_mode_i | input | 1 | 1 = frequency reading, 0 = voltage reading |
| unit_mhz_i | input | 1 | Frequency unit, 1 = MHz |
| positive_i | input | 1 | Voltage polarity, 1 = positive |
| lead_one_i | input | 1 | Leading half-digit value |
| dp_code_i | input | 2 | Decimal-point code |
| digit_a_i | input | 4 | BCD digit sent in bits 5:2 |
| digit_b_i | input | 4 | BCD digit sent in bits 9:6 |
| digit_c_i | input | 4 | BCD digit sent in bits 13:10 |
| init_state_i | input | 1 | No valid reading yet |
| ovl_pos_i | input | 1 | Positive overload |
| ovl_neg_i | input | 1 | Negative overload |
| host_sclk_i | input | 1 | Host serial clock, asynchronous |
| sdo_o | output | 1 | Serial data to host |
| eoc_o | output | 1 | Frame ready flag |

## Verification
The assertions assume that the host clock idles low, and that it holds each level for longer than the synchroniser latency. They also assume that the measurement fields are steady in the cycle in which the strobe is sampled. The stability property expects the data line to move only a fixed number of cycles after a host clock edge or after a strobe. The bench drives every input at the falling core edge and holds each host clock phase for six core cycles. It pulses the strobe for exactly one cycle and keeps the host clock low whenever it is not reading. The sweep covers every digit code from 0 to 15, including the clamped values. It also covers every decimal-point code, both modes and each special-frame priority.

// File: rtl/meas_serial_pkg.sv
package meas_serial_pkg;

    localparam int FRAME_W = 16;
    localparam int DIGIT_W = 4;

    localparam logic [5:0] CODE_INIT    = 6'b111111;
    localparam logic [5:0] CODE_OVL_POS = 6'b001111;
    localparam logic [5:0] CODE_OVL_NEG = 6'b001110;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic               freq_mode;
        logic               unit_mhz;
        logic               positive;
        logic               lead_one;
        logic [1:0]         dp_code;
        logic [DIGIT_W-1:0] dig_c;
        logic [DIGIT_W-1:0] dig_b;
        logic [DIGIT_W-1:0] dig_a;
    } reading_t;

    typedef struct packed {
        logic init_state;
        logic ovl_pos;
        logic ovl_neg;
    } special_t;

    typedef enum logic [1:0] {
        FR_NORMAL,
        FR_INIT,
        FR_OVL_POS,
        FR_OVL_NEG
    } frame_kind_e;

    function automatic logic [DIGIT_W-1:0] bcd_clamp(input logic [DIGIT_W-1:0] d);
        return (d > DIGIT_W'(9)) ? DIGIT_W'(9) : d;
    endfunction

    function automatic frame_kind_e pick_kind(input special_t s);
        if (s.init_state)   return FR_INIT;
        else if (s.ovl_pos) return FR_OVL_POS;
        else if (s.ovl_neg) return FR_OVL_NEG;
        else                return FR_NORMAL;
    endfunction

endpackage

// File: rtl/msp_sync_edge.sv
module msp_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o,
    output logic fall_o
);
    logic [STAGES-1:0] pipe;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= async_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[STAGES-2:0], async_i};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= pipe[STAGES-1];
    end

    assign rise_o =  pipe[STAGES-1] & ~last_q;
    assign fall_o = ~pipe[STAGES-1] &  last_q;
endmodule

// File: rtl/msp_frame_fmt.sv
module msp_frame_fmt
    import meas_serial_pkg::*;
(
    input  reading_t rd_i,
    input  special_t sp_i,
    output frame_t   frame_o
);
    frame_kind_e kind;
    logic        bit0;

    always_comb begin
        kind = pick_kind(sp_i);
        bit0 = rd_i.freq_mode ? rd_i.unit_mhz : rd_i.positive;
        unique case (kind)
            FR_INIT:    frame_o = {{(FRAME_W-6){1'b0}}, CODE_INIT};
            FR_OVL_POS: frame_o = {{(FRAME_W-6){1'b0}}, CODE_OVL_POS};
            FR_OVL_NEG: frame_o = {{(FRAME_W-6){1'b0}}, CODE_OVL_NEG};
            default:    frame_o = {rd_i.dp_code,
                                   bcd_clamp(rd_i.dig_c),
                                   bcd_clamp(rd_i.dig_b),
                                   bcd_clamp(rd_i.dig_a),
                                   rd_i.lead_one,
                                   bit0};
        endcase
    end
endmodule

// File: rtl/msp_shifter.sv
module msp_shifter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             step_i,
    output logic             bit_o
);
    logic [WIDTH-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst)         sreg <= '0;
        else if (load_i) sreg <= data_i;
        else if (step_i) sreg <= {1'b0, sreg[WIDTH-1:1]};
    end

    assign bit_o = sreg[0];
endmodule

// File: rtl/msp_eoc_timer.sv
module msp_eoc_timer #(
    parameter int TIMEOUT = 400000
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    localparam int          CW   = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            cnt    <= '0;
        end else if (set_i) begin
            flag_o <= 1'b1;
            cnt    <= '0;
        end else if (flag_o) begin
            if (clr_i || cnt == LAST) begin
                flag_o <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/meas_serial_port.sv
module meas_serial_port
    import meas_serial_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int EOC_TIMEOUT = 400000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       conv_done_i,
    input  logic       freq_mode_i,
    input  logic       unit_mhz_i,
    input  logic       positive_i,
    input  logic       lead_one_i,
    input  logic [1:0] dp_code_i,
    input  logic [3:0] digit_a_i,
    input  logic [3:0] digit_b_i,
    input  logic [3:0] digit_c_i,
    input  logic       init_state_i,
    input  logic       ovl_pos_i,
    input  logic       ovl_neg_i,
    input  logic       host_sclk_i,
    output logic       sdo_o,
    output logic       eoc_o
);
    reading_t rd;
    special_t sp;
    frame_t   frame;
    logic     sclk_rise;
    logic     sclk_fall;

    assign rd = '{freq_mode: freq_mode_i, unit_mhz: unit_mhz_i,
                  positive:  positive_i,  lead_one: lead_one_i,
                  dp_code:   dp_code_i,   dig_c:    digit_c_i,
                  dig_b:     digit_b_i,   dig_a:    digit_a_i};
    assign sp = '{init_state: init_state_i, ovl_pos: ovl_pos_i, ovl_neg: ovl_neg_i};

    msp_frame_fmt u_fmt (
        .rd_i    (rd),
        .sp_i    (sp),
        .frame_o (frame)
    );

    msp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (host_sclk_i),
        .rise_o  (sclk_rise),
        .fall_o  (sclk_fall)
    );

    msp_shifter #(.WIDTH(FRAME_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load_i (conv_done_i),
        .data_i (frame),
        .step_i (sclk_fall),
        .bit_o  (sdo_o)
    );

    msp_eoc_timer #(.TIMEOUT(EOC_TIMEOUT)) u_eoc (
        .clk    (clk),
        .rst    (rst),
        .set_i  (conv_done_i),
        .clr_i  (sclk_rise),
        .flag_o (eoc_o)
    );
endmodule

// File: rtl/meas_serial_port_chk.sv
module meas_serial_port_chk #(
    parameter int SYNC_STAGES = 2,
    parameter int EOC_TIMEOUT = 400000
) (
    input logic clk,
    input logic rst,
    input logic conv_done_i,
    input logic freq_mode_i,
    input logic unit_mhz_i,
    input logic positive_i,
    input logic init_state_i,
    input logic ovl_pos_i,
    input logic ovl_neg_i,
    input logic host_sclk_i,
    input logic sdo_o,
    input logic eoc_o
);
    localparam int CW    = $clog2(EOC_TIMEOUT + 1);
    localparam int QUIET = SYNC_STAGES + 4;
    localparam int QW    = $clog2(QUIET + 1);

    logic [CW-1:0] high_run;
    logic [QW-1:0] quiet_run;
    logic          sclk_d;
    logic          first_bit;

    always_ff @(posedge clk) begin
        if (rst)              high_run <= '0;
        else if (conv_done_i) high_run <= '0;
        else if (eoc_o)       high_run <= high_run + 1'b1;
        else                  high_run <= '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            quiet_run <= '0;
        end else begin
            sclk_d <= host_sclk_i;
            if (host_sclk_i != sclk_d)       quiet_run <= '0;
            else if (quiet_run != QW'(QUIET)) quiet_run <= quiet_run + 1'b1;
        end
    end

    always_comb begin
        if (init_state_i || ovl_pos_i) first_bit = 1'b1;
        else if (ovl_neg_i)            first_bit = 1'b0;
        else                           first_bit = freq_mode_i ? unit_mhz_i : positive_i;
    end

    // R2
    eoc_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc_o) |-> $past(conv_done_i));

    // R2
    eoc_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        conv_done_i |=> eoc_o);

    // R4
    eoc_window_chk: assert property (@(posedge clk) disable iff (rst)
        eoc_o |-> (high_run < CW'(EOC_TIMEOUT)));

    // R5 R10
    sdo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (quiet_run == QW'(QUIET) && !$past(conv_done_i)) |-> $stable(sdo_o));

    // R6 R8 R9
    first_bit_chk: assert property (@(posedge clk) disable iff (rst)
        conv_done_i |=> (sdo_o == $past(first_bit)));
endmodule

bind meas_serial_port meas_serial_port_chk #(
    .SYNC_STAGES (SYNC_STAGES),
    .EOC_TIMEOUT (EOC_TIMEOUT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .conv_done_i  (conv_done_i),
    .freq_mode_i  (freq_mode_i),
    .unit_mhz_i   (unit_mhz_i),
    .positive_i   (positive_i),
    .init_state_i (init_state_i),
    .ovl_pos_i    (ovl_pos_i),
    .ovl_neg_i    (ovl_neg_i),
    .host_sclk_i  (host_sclk_i),
    .sdo_o        (sdo_o),
    .eoc_o        (eoc_o)
);

// File: tb/meas_serial_port_test.sv
`timescale 1ns/1ps
module meas_serial_port_test;
    localparam int SYNC = 2;
    localparam int TMO  = 40;
    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_done_i = 1'b0;
    logic       freq_mode_i = 1'b0;
    logic       unit_mhz_i  = 1'b0;
    logic       positive_i  = 1'b0;
    logic       lead_one_i  = 1'b0;
    logic [1:0] dp_code_i   = 2'b00;
    logic [3:0] digit_a_i   = 4'd0;
    logic [3:0] digit_b_i   = 4'd0;
    logic [3:0] digit_c_i   = 4'd0;
    logic       init_state_i = 1'b0;
    logic       ovl_pos_i   = 1'b0;
    logic       ovl_neg_i   = 1'b0;
    logic       host_sclk_i = 1'b0;
    logic       sdo_o;
    logic       eoc_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [15:0] got;

    always #2.5 clk = ~clk;

    meas_serial_port #(.SYNC_STAGES(SYNC), .EOC_TIMEOUT(TMO)) uut (
        .clk(clk), .rst(rst), .conv_done_i(conv_done_i),
        .freq_mode_i(freq_mode_i), .unit_mhz_i(unit_mhz_i),
        .positive_i(positive_i), .lead_one_i(lead_one_i),
        .dp_code_i(dp_code_i), .digit_a_i(digit_a_i),
        .digit_b_i(digit_b_i), .digit_c_i(digit_c_i),
        .init_state_i(init_state_i), .ovl_pos_i(ovl_pos_i),
        .ovl_neg_i(ovl_neg_i), .host_sclk_i(host_sclk_i),
        .sdo_o(sdo_o), .eoc_o(eoc_o)
    );

    function automatic logic [3:0] clampd(input logic [3:0] d);
        return (d > 4'd9) ? 4'd9 : d;
    endfunction

    function automatic logic [15:0] expected();
        if (init_state_i) return 16'h003F;
        if (ovl_pos_i)    return 16'h000F;
        if (ovl_neg_i)    return 16'h000E;
        return {dp_code_i, clampd(digit_c_i), clampd(digit_b_i), clampd(digit_a_i),
                lead_one_i, (freq_mode_i ? unit_mhz_i : positive_i)};
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe();
        @(negedge clk) conv_done_i = 1'b1;
        @(negedge clk) conv_done_i = 1'b0;
    endtask

    task automatic read_bits(input int from, input int n);
        for (int i = from; i < from + n; i++) begin
            got[i] = sdo_o;
            host_sclk_i = 1'b1;
            repeat (HALF) @(negedge clk);
            host_sclk_i = 1'b0;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic set_fields(input logic fm, input logic mhz, input logic pos,
                              input logic lead, input logic [1:0] dp,
                              input logic [3:0] a, input logic [3:0] b, input logic [3:0] c);
        freq_mode_i = fm; unit_mhz_i = mhz; positive_i = pos; lead_one_i = lead;
        dp_code_i = dp; digit_a_i = a; digit_b_i = b; digit_c_i = c;
    endtask

    task automatic set_special(input logic ini, input logic op, input logic on);
        init_state_i = ini; ovl_pos_i = op; ovl_neg_i = on;
    endtask

    task automatic full_frame(input string req);
        logic [15:0] exp;
        exp = expected();
        strobe();
        check(eoc_o == 1'b1, "R2 eoc after strobe", {15'd0, eoc_o}, 16'd1);
        check(sdo_o == exp[0], "R2 bit0 after strobe", {15'd0, sdo_o}, {15'd0, exp[0]});
        got = '0;
        read_bits(0, 1);
        check(eoc_o == 1'b0, "R3 eoc cleared by host edge", {15'd0, eoc_o}, 16'd0);
        read_bits(1, 15);
        check(got == exp, req, got, exp);
        check(sdo_o == 1'b0, "R5 zero after last bit", {15'd0, sdo_o}, 16'd0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] exp;
        repeat (3) @(negedge clk);
        check(sdo_o == 1'b0 && eoc_o == 1'b0, "R1 during reset", {14'd0, sdo_o, eoc_o}, 16'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(sdo_o == 1'b0 && eoc_o == 1'b0, "R1 after reset", {14'd0, sdo_o, eoc_o}, 16'd0);

        // R6 R7 R8 R5: sweep of all digit codes, dp codes, both modes
        for (int v = 0; v < 16; v++) begin
            set_fields((v % 3) == 0, v[2], v[0], v[1], v[3:2],
                       4'(v), 4'((v + 5) % 16), 4'((v + 11) % 16));
            full_frame((v % 3) == 0 ? "R8 frequency frame" : "R6 R7 voltage frame");
        end

        // R9: special frames and priority
        set_fields(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 4'd7, 4'd8, 4'd9);
        set_special(1'b1, 1'b0, 1'b0); full_frame("R9 initial state");
        set_special(1'b0, 1'b1, 1'b0); full_frame("R9 positive overload");
        set_special(1'b0, 1'b0, 1'b1); full_frame("R9 negative overload");
        set_special(1'b1, 1'b1, 1'b1); full_frame("R9 initial beats overload");
        set_special(1'b0, 1'b1, 1'b1); full_frame("R9 positive beats negative");
        set_special(1'b0, 1'b0, 1'b0);

        // R4: timeout with no host clock
        set_fields(1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 4'd1, 4'd2, 4'd3);
        strobe();
        repeat (TMO - 1) @(negedge clk);
        check(eoc_o == 1'b1, "R4 eoc high at last timeout cycle", {15'd0, eoc_o}, 16'd1);
        @(negedge clk);
        check(eoc_o == 1'b0, "R4 eoc low after timeout", {15'd0, eoc_o}, 16'd0);

        // R10: inputs change mid-read without strobe
        set_fields(1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 4'd4, 4'd5, 4'd6);
        exp = expected();
        strobe();
        got = '0;
        read_bits(0, 4);
        set_fields(1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 4'd9, 4'd0, 4'd3);
        read_bits(4, 12);
        check(got == exp, "R10 inputs ignored without strobe", got, exp);

        // R10: strobe mid-read restarts at bit 0
        set_fields(1'b0, 1'b0, 1'b0, 1'b1, 2'b11, 4'd8, 4'd2, 4'd1);
        strobe();
        read_bits(0, 5);
        set_fields(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 4'd3, 4'd7, 4'd5);
        exp = expected();
        strobe();
        got = '0;
        read_bits(0, 16);
        check(got == exp, "R10 strobe restarts frame", got, exp);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule